// File: doc/BRIEF.md
# Double-Buffered Crosspoint Switch

This block routes sixteen single-bit data lanes onto sixteen output lanes through a non-blocking crosspoint. Every output has its own 16:1 selector, so an input can feed any number of outputs at the same time. Each selector is steered by an entry in an active configuration table. A second, staging table sits in front of it. A host fills the staging table one output at a time. It then commits the whole table in a single clock, so every changed route switches at the same moment.

All control inputs are sampled as enables on the rising edge of one clock. The data path itself is a purely combinational selection by default. A parameter can add one register stage on the outputs. A synchronous map reset puts the switch in a known state. With commit low, every output carries input 0 (broadcast). With commit high, output i carries input i (pass-through). Because the staging table is left at the identity map after any reset, a commit issued after a broadcast reset gives pass-through.

Top module: `xbar_switch`

## Requirements
- R1: Each output carries the input named by its own active entry, independently of the others; several outputs may carry the same input at once.
- R2: At a rising edge with `load` high and `mapRst` low, the staging entry of output `outSel` (binary n selects output n) takes `inSel` (binary n names input n).
- R3: With `load` low, `inSel` and `outSel` are ignored and no staging entry changes.
- R4: Outputs follow only the active table; staged entries that have not been committed have no effect on `dataOut`.
- R5: A rising edge with `commit` high and `mapRst` low copies all sixteen staging entries into the active table at once.
- R6: An output whose active entry keeps its value across a commit keeps carrying its input, with the same value before and after the commit edge.
- R7: A rising edge with `mapRst` high and `commit` low sets every active entry to 0 (broadcast from input 0) and every staging entry i to i, overwriting the earlier configuration.
- R8: A commit issued after a broadcast reset, with no writes in between, gives pass-through: output i carries input i.
- R9: A rising edge with `mapRst` and `commit` both high sets both tables to the identity map at once, giving pass-through directly.
- R10: While `mapRst` is high, `load` has no effect; the staging table still ends at the identity map.
- R11: When `load` and `commit` are both high in the same cycle, the commit copies the staging values from before the write. The new value reaches the active table only at the next commit.
- R12: With the default `OUT_REG` of 0, `dataOut` responds to a change on `dataIn` in the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all control is sampled on its rising edge |
| mapRst | input | 1 | Synchronous map reset: broadcast, or pass-through when `commit` is also high |
| load | input | 1 | Write enable for the staging entry chosen by `outSel` |
| commit | input | 1 | Copies the whole staging table into the active table |
| inSel | input | 4 | Input index written into the staging entry |
| outSel | input | 4 | Output whose staging entry is written |
| dataIn | input | 16 | Data input lanes |
| dataOut | output | 16 | Data output lanes |

## Verification
A staging write and a commit can land on the same edge. A map reset can also coincide with either of them. The bench drives `load` and `commit` together on an output whose staged value is about to change. It then checks that the active route still takes the old staged value, and that the new value appears only after a second commit. It also raises `mapRst` together with `load` and with `commit`. The routes are judged at the ports with walking-one data patterns, which identify every output's source uniquely.

// File: rtl/xbar_pkg.sv
`timescale 1ns/1ps
package xbar_pkg;
  // Strobes decoded by the control module for the datapath.
  typedef struct packed {
    logic write;     // staging write this cycle
    logic commit;    // copy staging -> active
    logic mapBcast;  // reset to broadcast map
    logic mapPass;   // reset to pass-through map
  } xbar_ctl_t;
endpackage

// File: rtl/xbar_ctrl.sv
`timescale 1ns/1ps
module xbar_ctrl
  import xbar_pkg::*;
#(
  parameter int N_PORTS = 16,
  localparam int SEL_W = $clog2(N_PORTS)
) (
  input  logic             clk,
  input  logic             mapRst,
  input  logic             load,
  input  logic             commit,
  input  logic [SEL_W-1:0] outSel,
  output xbar_ctl_t        ctl,
  output logic [N_PORTS-1:0] wrOneHot
);
  // Map reset dominates: load and commit only act outside of it.
  always_comb begin
    ctl.write    = load & ~mapRst;
    ctl.commit   = commit & ~mapRst;
    ctl.mapBcast = mapRst & ~commit;
    ctl.mapPass  = mapRst & commit;
  end

  // Output-select decoder, gated by the write strobe.
  always_comb begin
    wrOneHot = '0;
    if (ctl.write) wrOneHot[outSel] = 1'b1;
  end

  // R2: a write names exactly one staging entry.
  a_r2_one_target: assert property (@(posedge clk) disable iff (mapRst)
    load |-> $onehot(wrOneHot));
  // R3, R10: no write strobe without load, or during a map reset.
  a_r3_no_stray_write: assert property (@(posedge clk)
    (!load || mapRst) |-> (wrOneHot == '0));
  a_r9_reset_modes_exclusive: assert property (@(posedge clk)
    $onehot0({ctl.mapBcast, ctl.mapPass, ctl.commit}));
endmodule

// File: rtl/xbar_datapath.sv
`timescale 1ns/1ps
module xbar_datapath
  import xbar_pkg::*;
#(
  parameter int N_PORTS = 16,
  parameter bit OUT_REG = 1'b0,
  localparam int SEL_W = $clog2(N_PORTS)
) (
  input  logic               clk,
  input  logic               mapRst,
  input  xbar_ctl_t          ctl,
  input  logic [N_PORTS-1:0] wrOneHot,
  input  logic [SEL_W-1:0]   inSel,
  input  logic [N_PORTS-1:0] dataIn,
  output logic [N_PORTS-1:0] dataOut
);
  logic [SEL_W-1:0]   stageReg  [N_PORTS];
  logic [SEL_W-1:0]   activeReg [N_PORTS];
  logic [N_PORTS-1:0] selData;

  for (genvar p = 0; p < N_PORTS; p++) begin : g_port
    // Two-stage configuration entry for output p.
    always_ff @(posedge clk) begin
      if (ctl.mapBcast) begin
        stageReg[p]  <= SEL_W'(p);
        activeReg[p] <= '0;
      end else if (ctl.mapPass) begin
        stageReg[p]  <= SEL_W'(p);
        activeReg[p] <= SEL_W'(p);
      end else begin
        if (ctl.commit)  activeReg[p] <= stageReg[p];
        if (wrOneHot[p]) stageReg[p]  <= inSel;
      end
    end

    // Per-output 16:1 selector driven only by the active entry.
    always_comb selData[p] = dataIn[activeReg[p]];

    // R5, R11: commit copies the pre-write staging value.
    a_r5_commit_copy: assert property (@(posedge clk) disable iff (mapRst)
      ctl.commit |=> (activeReg[p] == $past(stageReg[p])));
    // R4: active entry only moves on commit or map reset.
    a_r4_active_hold: assert property (@(posedge clk) disable iff (mapRst)
      !ctl.commit |=> $stable(activeReg[p]));
    // R3: staging entry only moves when addressed by a write.
    a_r3_stage_hold: assert property (@(posedge clk) disable iff (mapRst)
      !wrOneHot[p] |=> $stable(stageReg[p]));
  end

  if (OUT_REG) begin : g_outq
    always_ff @(posedge clk) dataOut <= selData;
  end else begin : g_comb
    always_comb dataOut = selData;
  end
endmodule

// File: rtl/xbar_switch.sv
`timescale 1ns/1ps
module xbar_switch
  import xbar_pkg::*;
#(
  parameter int N_PORTS = 16,
  parameter bit OUT_REG = 1'b0,
  localparam int SEL_W = $clog2(N_PORTS)
) (
  input  logic               clk,
  input  logic               mapRst,
  input  logic               load,
  input  logic               commit,
  input  logic [SEL_W-1:0]   inSel,
  input  logic [SEL_W-1:0]   outSel,
  input  logic [N_PORTS-1:0] dataIn,
  output logic [N_PORTS-1:0] dataOut
);
  xbar_ctl_t          ctl;
  logic [N_PORTS-1:0] wrOneHot;

  xbar_ctrl #(.N_PORTS(N_PORTS)) u_ctrl (
    .clk(clk), .mapRst(mapRst), .load(load), .commit(commit),
    .outSel(outSel), .ctl(ctl), .wrOneHot(wrOneHot)
  );

  xbar_datapath #(.N_PORTS(N_PORTS), .OUT_REG(OUT_REG)) u_dp (
    .clk(clk), .mapRst(mapRst), .ctl(ctl), .wrOneHot(wrOneHot),
    .inSel(inSel), .dataIn(dataIn), .dataOut(dataOut)
  );
endmodule

// File: tb/xbar_switch_test.sv
`timescale 1ns/1ps
module xbar_switch_test;
  localparam int N = 16;
  localparam int NV = 8;
  // {outSel, inSel} staging writes; outputs 3 and 9 both take input 10 (fan-out).
  localparam logic [7:0] VEC [NV] = '{8'h3A, 8'h9A, 8'h0F, 8'hF0,
                                      8'h57, 8'hC2, 8'h1E, 8'h64};

  logic clk = 1'b0;
  logic mapRst = 1'b1, load = 1'b0, commit = 1'b0;
  logic [3:0] inSel = '0, outSel = '0;
  logic [N-1:0] dataIn = '0;
  logic [N-1:0] dataOut;

  int nChk = 0, nBad = 0;
  bit done = 1'b0;
  logic [3:0] stM [N];
  logic [3:0] actM [N];

  always #10 clk = ~clk;

  xbar_switch uut (.clk(clk), .mapRst(mapRst), .load(load), .commit(commit),
                   .inSel(inSel), .outSel(outSel), .dataIn(dataIn), .dataOut(dataOut));

  function automatic logic [N-1:0] expOut(logic [N-1:0] pat);
    logic [N-1:0] e;
    for (int k = 0; k < N; k++) e[k] = pat[actM[k]];
    return e;
  endfunction

  // One clocked control step; the model applies the requirement rules.
  task automatic step(input logic r, input logic l, input logic c,
                      input logic [3:0] ia, input logic [3:0] oa);
    logic [3:0] old [N];
    @(negedge clk);
    mapRst = r; load = l; commit = c; inSel = ia; outSel = oa;
    @(posedge clk);
    for (int k = 0; k < N; k++) old[k] = stM[k];
    if (r) begin                                   // R7, R9, R10
      for (int k = 0; k < N; k++) begin
        stM[k] = 4'(k);
        actM[k] = c ? 4'(k) : 4'd0;
      end
    end else begin
      if (c) for (int k = 0; k < N; k++) actM[k] = old[k];  // R5, R11
      if (l) stM[oa] = ia;                                  // R2
    end
    @(negedge clk);
    mapRst = 1'b0; load = 1'b0; commit = 1'b0;
  endtask

  task automatic cmp(input string req, input logic [N-1:0] got, input logic [N-1:0] exp);
    nChk++;
    if (got !== exp) begin
      nBad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // Walking-one patterns identify each output's source; plus one mixed word.
  task automatic checkMap(input string req);
    for (int b = 0; b <= N; b++) begin
      dataIn = (b == N) ? 16'hA5C3 : (16'h1 << b);
      #1;
      cmp(req, dataOut, expOut(dataIn));
    end
  endtask

  initial begin
    for (int k = 0; k < N; k++) begin stM[k] = '0; actM[k] = '0; end
    step(1'b1, 1'b0, 1'b0, 4'd0, 4'd0);
    checkMap("R7 broadcast after reset");
    dataIn = 16'h0001; #1;
    cmp("R7 all outputs from input 0", dataOut, 16'hFFFF);

    step(1'b0, 1'b0, 1'b1, 4'd0, 4'd0);
    checkMap("R8 commit after broadcast reset");
    dataIn = 16'h3C96; #1;
    cmp("R8 pass-through", dataOut, 16'h3C96);

    // Table walk: stage, verify no effect, commit, verify routes.
    for (int v = 0; v < NV; v++) step(1'b0, 1'b1, 1'b0, VEC[v][3:0], VEC[v][7:4]);
    checkMap("R4 staged but not committed");
    dataIn = 16'h00F0; #1;
    cmp("R4 still pass-through", dataOut, 16'h00F0);
    step(1'b0, 1'b0, 1'b1, 4'd0, 4'd0);
    checkMap("R1 R2 R5 table routes");
    dataIn = 16'h0400; #1;
    cmp("R1 fan-out of input 10", dataOut & 16'h0208, 16'h0208);

    // R3: address lines wiggle with load low.
    for (int v = 0; v < 4; v++) step(1'b0, 1'b0, 1'b0, 4'(v + 3), 4'(v));
    step(1'b0, 1'b0, 1'b1, 4'd0, 4'd0);
    checkMap("R3 load low ignored");

    // R6: output 3 stays on input 10 across a commit that moves output 5.
    step(1'b0, 1'b1, 1'b0, 4'd1, 4'd5);
    dataIn = 16'h0400;
    @(posedge clk); #2;
    cmp("R6 before commit", {15'd0, dataOut[3]}, 16'd1);
    step(1'b0, 1'b0, 1'b1, 4'd0, 4'd0);
    dataIn = 16'h0400; #1;
    cmp("R6 after commit", {15'd0, dataOut[3]}, 16'd1);
    checkMap("R6 map after commit");

    // R11: write and commit together on output 0.
    step(1'b0, 1'b1, 1'b1, 4'd9, 4'd0);
    dataIn = 16'h0200; #1;
    cmp("R11 old value committed", {15'd0, dataOut[0]}, 16'd0);
    checkMap("R11 map");
    step(1'b0, 1'b0, 1'b1, 4'd0, 4'd0);
    dataIn = 16'h0200; #1;
    cmp("R11 new value on next commit", {15'd0, dataOut[0]}, 16'd1);

    // R10: reset with load high; R8 pass-through follows.
    step(1'b1, 1'b1, 1'b0, 4'd7, 4'd2);
    checkMap("R10 reset with load high");
    step(1'b0, 1'b0, 1'b1, 4'd0, 4'd0);
    dataIn = 16'h5A0F; #1;
    cmp("R10 staging identity after reset", dataOut, 16'h5A0F);

    // R9: reset with commit high gives pass-through directly.
    step(1'b0, 1'b1, 1'b0, 4'd4, 4'd4);
    step(1'b0, 1'b0, 1'b1, 4'd0, 4'd0);
    step(1'b1, 1'b0, 1'b1, 4'd0, 4'd0);
    dataIn = 16'hC3A5; #1;
    cmp("R9 direct pass-through", dataOut, 16'hC3A5);

    // R12: combinational path, no clock edge between change and sample.
    @(negedge clk);
    dataIn = 16'h1234; #1;
    cmp("R12 same-cycle response", dataOut, 16'h1234);
    dataIn = 16'hEDCB; #1;
    cmp("R12 second change", dataOut, 16'hEDCB);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      nChk++; nBad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end
endmodule